// File: doc/BRIEF.md
# Serial FSK Byte Deframer with Host Read Clock

This block sits behind an FSK demodulator. It receives the demodulated bit stream, which idles high and uses asynchronous framing at 1200 bit/s, together with an active-low carrier-detect qualifier. It hands the data to a host controller in one of two modes, chosen by a pin. In raw mode the stream goes straight to the serial data output. In buffered mode the block finds each start bit, samples the eight data bits and the stop bit at their centres, and holds them in a nine-bit buffer. It then pulls an active-low ready flag and lets the host step through the bits with its own read clock.

The ready flag is released in one of two ways. The first read-clock rising edge releases it, so that edge also clears the host interrupt. If no edge arrives, the flag releases itself after half a nominal bit time. The host may read only the eight data bits, or it may read the stop bit as well to check for a framing error. The bit timing comes from the system clock through the `CYC_PER_BIT` parameter.

Top module: `fsk_deframer`

## Requirements
- R1: With `mode_buf` low and `carrier_n` low, `data_out` follows `fsk_bit` combinationally, and `rdy_n` stays high.
- R2: With `mode_buf` low and `carrier_n` high, `data_out` is forced to 1 whatever `fsk_bit` does.
- R3: In buffered mode, a valid frame loads the buffer at the centre of its stop bit. In the next cycle `rdy_n` goes low and `data_out` shows data bit 0.
- R4: Each synchronised rising edge of `rd_clk` advances `data_out` by one position, least significant data bit first. Position 8 is the stop bit exactly as received, whether it is 0 or 1.
- R5: Once the stop bit is shown (after eight read edges), further read edges leave `data_out` unchanged.
- R6: If a read edge arrives while `rdy_n` is low, `rdy_n` returns high no more than three clock cycles after `rd_clk` rises.
- R7: With no read edge, `rdy_n` stays low for exactly `CYC_PER_BIT/2` clock cycles and then returns high.
- R8: While `carrier_n` is high, no frame is loaded. `rdy_n` stays high and the buffer and `data_out` keep their values.
- R9: A low pulse on `fsk_bit` that is high again at the start-bit centre is discarded: no load and no change on `rdy_n`.
- R10: A frame that completes before the host has finished reading replaces the buffer, restarts the read position at bit 0 and pulls `rdy_n` low again.
- R11: After reset, `rdy_n` is high and `data_out` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_buf | input | 1 | 1 = buffered mode, 0 = raw pass-through |
| carrier_n | input | 1 | Carrier detect, active low |
| fsk_bit | input | 1 | Demodulated bit stream, idle high |
| rd_clk | input | 1 | Host read clock, asynchronous |
| data_out | output | 1 | Serial data to host |
| rdy_n | output | 1 | Data-ready flag, active low |

## Verification
The hardest case to reach is a read edge that lands inside the short window in which `rdy_n` is low. That window opens in the middle of a stop bit, while the frame is still arriving. The bench therefore runs the frame driver and a reader in parallel. The reader waits for the falling edge of `rdy_n` and raises `rd_clk` at once, so the release by the read edge can be told apart from the half-bit timeout. Overwriting the buffer is reached by sending two frames back to back without reading.

// File: rtl/fsk_deframe_pkg.sv
package fsk_deframe_pkg;
  localparam int DATA_W  = 8;
  localparam int FRAME_W = DATA_W + 1;
  localparam int PTR_W   = $clog2(FRAME_W);

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;
endpackage

// File: rtl/fsk_frame_rx.sv
module fsk_frame_rx
  import fsk_deframe_pkg::*;
#(
  parameter int CYC_PER_BIT = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               bit_in,
  output logic               ld_vld,
  output logic [FRAME_W-1:0] ld_frame
);
  localparam int CNT_W = $clog2(CYC_PER_BIT);
  localparam int HALF  = CYC_PER_BIT / 2;

  rx_state_e          state_q, state_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [2:0]         idx_q, idx_d;
  logic [DATA_W-1:0]  sh_q, sh_d;
  logic               prev_q, prev_d;
  logic               vld_q, vld_d;
  logic [FRAME_W-1:0] frm_q, frm_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q + CNT_W'(1);
    idx_d   = idx_q;
    sh_d    = sh_q;
    vld_d   = 1'b0;
    frm_d   = frm_q;
    prev_d  = en ? bit_in : 1'b1;
    unique case (state_q)
      RX_IDLE: begin
        cnt_d = '0;
        if (prev_q && !bit_in) state_d = RX_START;
      end
      RX_START: begin
        if (cnt_q == CNT_W'(HALF - 1)) begin
          cnt_d   = '0;
          idx_d   = '0;
          state_d = bit_in ? RX_IDLE : RX_DATA;
        end
      end
      RX_DATA: begin
        if (cnt_q == CNT_W'(CYC_PER_BIT - 1)) begin
          cnt_d       = '0;
          sh_d[idx_q] = bit_in;
          idx_d       = idx_q + 3'd1;
          if (idx_q == 3'(DATA_W - 1)) state_d = RX_STOP;
        end
      end
      RX_STOP: begin
        if (cnt_q == CNT_W'(CYC_PER_BIT - 1)) begin
          vld_d   = 1'b1;
          frm_d   = {bit_in, sh_q};
          state_d = RX_IDLE;
        end
      end
      default: state_d = RX_IDLE;
    endcase
    if (!en) begin
      state_d = RX_IDLE;
      vld_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      prev_q  <= 1'b1;
      vld_q   <= 1'b0;
      frm_q   <= '1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      sh_q    <= sh_d;
      prev_q  <= prev_d;
      vld_q   <= vld_d;
      frm_q   <= frm_d;
    end
  end

  assign ld_vld   = vld_q;
  assign ld_frame = frm_q;
endmodule

// File: rtl/fsk_rd_sync.sv
module fsk_rd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_async,
  output logic rd_rise
);
  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[STAGES-1:0], rd_async};
  end

  assign rd_rise = pipe_q[STAGES-1] & ~pipe_q[STAGES];
endmodule

// File: rtl/fsk_out_buf.sv
module fsk_out_buf
  import fsk_deframe_pkg::*;
#(
  parameter int CYC_PER_BIT = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode_buf,
  input  logic               ld_vld,
  input  logic [FRAME_W-1:0] ld_frame,
  input  logic               rd_edge,
  output logic               buf_bit,
  output logic               rdy_n,
  output logic [PTR_W-1:0]   rd_ptr
);
  localparam int HALF  = CYC_PER_BIT / 2;
  localparam int TMR_W = $clog2(CYC_PER_BIT);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] buf_q, buf_d;
  logic [PTR_W-1:0]   ptr_q, ptr_d;
  logic               rdy_q, rdy_d;
  logic [TMR_W-1:0]   tmr_q, tmr_d;

  always_comb begin
    buf_d = buf_q;
    ptr_d = ptr_q;
    rdy_d = rdy_q;
    tmr_d = tmr_q;
    if (ld_vld) begin
      buf_d = ld_frame;
      ptr_d = '0;
      rdy_d = 1'b0;
      tmr_d = '0;
    end else begin
      if (rd_edge && ptr_q != LAST) ptr_d = ptr_q + PTR_W'(1);
      if (!rdy_q) begin
        if (rd_edge)                         rdy_d = 1'b1;
        else if (tmr_q == TMR_W'(HALF - 1))  rdy_d = 1'b1;
        else                                 tmr_d = tmr_q + TMR_W'(1);
      end
    end
    if (!mode_buf) rdy_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '1;
      ptr_q <= LAST;
      rdy_q <= 1'b1;
      tmr_q <= '0;
    end else begin
      buf_q <= buf_d;
      ptr_q <= ptr_d;
      rdy_q <= rdy_d;
      tmr_q <= tmr_d;
    end
  end

  assign buf_bit = buf_q[ptr_q];
  assign rdy_n   = rdy_q;
  assign rd_ptr  = ptr_q;
endmodule

// File: rtl/fsk_deframer.sv
module fsk_deframer
  import fsk_deframe_pkg::*;
#(
  parameter int CYC_PER_BIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_buf,
  input  logic carrier_n,
  input  logic fsk_bit,
  input  logic rd_clk,
  output logic data_out,
  output logic rdy_n
);
  logic               rx_en;
  logic               ld_vld;
  logic [FRAME_W-1:0] ld_frame;
  logic               rd_edge;
  logic [PTR_W-1:0]   rd_ptr;
  logic               buf_bit;

  assign rx_en = mode_buf & ~carrier_n;

  fsk_frame_rx #(.CYC_PER_BIT(CYC_PER_BIT)) i_rx (
    .clk(clk), .rst_n(rst_n), .en(rx_en), .bit_in(fsk_bit),
    .ld_vld(ld_vld), .ld_frame(ld_frame)
  );

  fsk_rd_sync #(.STAGES(2)) i_sync (
    .clk(clk), .rst_n(rst_n), .rd_async(rd_clk), .rd_rise(rd_edge)
  );

  fsk_out_buf #(.CYC_PER_BIT(CYC_PER_BIT)) i_buf (
    .clk(clk), .rst_n(rst_n), .mode_buf(mode_buf), .ld_vld(ld_vld),
    .ld_frame(ld_frame), .rd_edge(rd_edge), .buf_bit(buf_bit),
    .rdy_n(rdy_n), .rd_ptr(rd_ptr)
  );

  assign data_out = mode_buf ? buf_bit : (carrier_n | fsk_bit);
endmodule

// File: rtl/fsk_deframer_chk.sv
module fsk_deframer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mode_buf,
  input logic       carrier_n,
  input logic       rdy_n,
  input logic       ld_vld,
  input logic       rd_edge,
  input logic [3:0] rd_ptr
);
  // R1
  raw_rdy_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_buf && $past(!mode_buf)) |-> rdy_n);

  // R3
  load_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_vld && mode_buf) |=> (!rdy_n && rd_ptr == 4'd0));

  // R4
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_edge && !ld_vld && rd_ptr != 4'd8) |=> (rd_ptr == $past(rd_ptr) + 4'd1));

  // R5
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ptr == 4'd8 && !ld_vld) |=> (rd_ptr == 4'd8));

  // R6
  read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdy_n && rd_edge && !ld_vld) |=> rdy_n);

  // R8
  no_carrier_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    carrier_n |=> !ld_vld);
endmodule

bind fsk_deframer fsk_deframer_chk i_chk (
  .clk(clk), .rst_n(rst_n), .mode_buf(mode_buf), .carrier_n(carrier_n),
  .rdy_n(rdy_n), .ld_vld(ld_vld), .rd_edge(rd_edge), .rd_ptr(rd_ptr)
);

// File: tb/test_fsk_deframer.sv
module test_fsk_deframer;
  localparam int CLK_PERIOD = 10;
  localparam int CPB        = 16;
  localparam int HALF       = CPB / 2;

  logic clk, rst_n, mode_buf, carrier_n, fsk_bit, rd_clk;
  logic data_out, rdy_n;

  int n_tests = 0;
  int n_fail  = 0;
  logic [8:0] exp_q[$];
  logic prev_rdy = 1'b1;

  fsk_deframer #(.CYC_PER_BIT(CPB)) i_fsk_deframer (
    .clk(clk), .rst_n(rst_n), .mode_buf(mode_buf), .carrier_n(carrier_n),
    .fsk_bit(fsk_bit), .rd_clk(rd_clk), .data_out(data_out), .rdy_n(rdy_n)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: pushes expected frame, then drives start, data (LSB first), stop, idle
  task automatic send_frame(input logic [7:0] b, input logic stop, input bit expect_load);
    if (expect_load) exp_q.push_back({stop, b});
    fsk_bit = 1'b0; tick(CPB);
    for (int i = 0; i < 8; i++) begin fsk_bit = b[i]; tick(CPB); end
    fsk_bit = stop; tick(CPB);
    fsk_bit = 1'b1; tick(2*CPB);
  endtask

  task automatic pulse_rd();
    rd_clk = 1'b1; tick(4);
    rd_clk = 1'b0; tick(4);
  endtask

  task automatic wait_rdy_fall();
    do @(negedge clk); while (rdy_n);
  endtask

  // reader: pops newest expected frame and compares serial bits
  task automatic read_bits(input int from);
    logic [8:0] exp;
    exp = exp_q[$];
    exp_q.delete();
    for (int i = from; i < 9; i++) begin
      check(data_out == exp[i], "R4 serial bit", data_out, exp[i]);
      if (i < 8) pulse_rd();
    end
    for (int k = 0; k < 3; k++) begin
      pulse_rd();
      check(data_out == exp[8], "R5 extra read edge", data_out, exp[8]);
    end
  endtask

  // monitor: every ready assertion must match an expected frame
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && prev_rdy && !rdy_n) begin
        n_tests++;
        if (exp_q.size() == 0) begin
          n_fail++;
          $display("FAIL R8 R9 unexpected load actual=rdy_n 0 expected=rdy_n 1");
        end
      end
      prev_rdy = rdy_n;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode_buf = 1'b1; carrier_n = 1'b0; fsk_bit = 1'b1; rd_clk = 1'b0;
    tick(5);
    check(rdy_n == 1'b1, "R11 reset rdy_n", rdy_n, 1);
    check(data_out == 1'b1, "R11 reset data_out", data_out, 1);
    rst_n = 1'b1;
    tick(3);

    // R3 R7: timeout release
    fork
      send_frame(8'hA5, 1'b1, 1'b1);
      begin
        wait_rdy_fall();
        check(data_out == 1'b1, "R3 bit0 after load", data_out, 1);
        tick(HALF - 1);
        check(rdy_n == 1'b0, "R7 still low", rdy_n, 0);
        tick(1);
        check(rdy_n == 1'b1, "R7 timeout release", rdy_n, 1);
      end
    join
    read_bits(0);

    // R6: early read release
    fork
      send_frame(8'h3C, 1'b1, 1'b1);
      begin
        wait_rdy_fall();
        check(data_out == 1'b0, "R3 bit0 after load", data_out, 0);
        rd_clk = 1'b1; tick(4);
        check(rdy_n == 1'b1, "R6 read edge release", rdy_n, 1);
        rd_clk = 1'b0; tick(4);
      end
    join
    read_bits(1);

    // R4 R5: stop bit received as 0
    send_frame(8'h5A, 1'b0, 1'b1);
    read_bits(0);

    // R8: carrier inactive, buffer still shows stop bit 0
    carrier_n = 1'b1;
    send_frame(8'hFF, 1'b1, 1'b0);
    check(rdy_n == 1'b1, "R8 no ready", rdy_n, 1);
    check(data_out == 1'b0, "R8 buffer unchanged", data_out, 0);
    carrier_n = 1'b0;
    tick(4);

    // R9: short low pulse
    fsk_bit = 1'b0; tick(HALF/2);
    fsk_bit = 1'b1; tick(2*CPB);
    check(rdy_n == 1'b1, "R9 false start rdy_n", rdy_n, 1);
    check(data_out == 1'b0, "R9 false start data_out", data_out, 0);

    // R10: overwrite before read
    send_frame(8'h0F, 1'b1, 1'b1);
    send_frame(8'h96, 1'b1, 1'b1);
    check(data_out == 1'b0, "R10 overwrite bit0", data_out, 0);
    read_bits(0);

    // R1 R2: raw mode
    mode_buf = 1'b0;
    tick(3);
    fsk_bit = 1'b0; tick(1);
    check(data_out == 1'b0, "R1 raw low", data_out, 0);
    fsk_bit = 1'b1; tick(1);
    check(data_out == 1'b1, "R1 raw high", data_out, 1);
    check(rdy_n == 1'b1, "R1 raw rdy_n", rdy_n, 1);
    carrier_n = 1'b1;
    fsk_bit = 1'b0; tick(1);
    check(data_out == 1'b1, "R2 forced high", data_out, 1);
    fsk_bit = 1'b1; tick(2);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule